// File: doc/BRIEF.md
# Rotate-and-Add Byte Whitener

This block is a post-processing stage for a random bit source. It takes raw random bytes that arrive with a one-cycle valid strobe, collects a fixed number of them, and mixes them into one output byte. For each raw byte it accepts, it first rotates the running accumulator right by one bit position and then adds the new byte modulo 2^W. The rotation moves each raw bit into a different lane before the next addition. The carries of the additions then spread its influence into the higher lanes. With the default group of 8 raw bytes of 8 bits, all 64 raw bits feed the single output byte.

The stage is placed between a de-biasing extractor and the consumer. The consumer has to capture `out_o` in the one cycle in which `out_vld_o` is high. The extractor delivers at most one raw byte per 16 cycles, so one whitened byte takes at least 128 cycles. The stage does not depend on that rate, though: it accepts one raw byte on every cycle in which the raw strobe is high, including on consecutive cycles. Driving the enable low discards a partly collected group.

Top module: `mix_whitener`

## Requirements
- R1: While `rst_ni` is sampled low, the block clears its state. On the cycle after a reset edge, `out_vld_o` is 0 and `out_o` is 0.
- R2: Each accepted raw byte `r` updates the accumulator `a` to `((a >> 1) | (a[0] << (W-1))) + r` modulo 2^W, where `>>` is a logical shift. This is a right rotation by one bit followed by an addition.
- R3: Exactly NUM_RAW (default 8) accepted raw bytes make one output byte. The accumulator starts at 0 for each group. On the clock edge that accepts the last byte of a group, `out_o` takes the updated accumulator value and `out_vld_o` goes high. Both are visible in the cycle after that edge.
- R4: `out_vld_o` is high for exactly one cycle for each output byte.
- R5: After a group is emitted, the accumulator and the byte count restart from zero, so every group is independent of the groups before it.
- R6: While `en_i` is sampled low, the accumulator and the byte count are cleared, raw strobes are ignored, and `out_vld_o` stays 0. A partly collected group is therefore discarded.
- R7: Raw strobes on consecutive cycles are each accepted. No byte is lost.
- R8: On cycles where `raw_vld_i` is 0, the value on `raw_i` has no effect on any later output.
- R9: `out_o` keeps its last value until the next output pulse. Dropping the enable does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Stage enable; when low, clears the accumulator and the byte count |
| raw_i | input | W (8) | Raw random byte |
| raw_vld_i | input | 1 | Strobe; high for one cycle for each raw byte offered |
| out_o | output | W (8) | Whitened byte, held between pulses |
| out_vld_o | output | 1 | One-cycle pulse marking a new `out_o` |

## Verification
The bench runs a near-exhaustive sweep in which a single raw bit is set in each of the 64 raw bit positions of a group in turn. No carries occur in this sweep, so the expected output is a single bit placed by the number of rotations that follow that byte. This pattern isolates the rotation direction and the order of the bytes. Groups of all-ones bytes and counting sequences check that carries are added modulo 2^W, and the result of each group is compared against an arithmetic model of the recurrence. The same groups are driven back-to-back and with idle gaps that carry junk on the data lines. This tells acceptance on consecutive strobes apart from gating by the strobe. An enable drop in the middle of a group, with strobes held high during the drop, shows that the partial group is discarded and that the held output survives.

// File: rtl/mix_whitener_pkg.sv
// Package: shared control type for the rotate-and-add whitener.
// Assumes nothing beyond synthesizable SystemVerilog.
package mix_whitener_pkg;

    // Per-cycle step decision issued by the group counter.
    typedef struct packed {
        logic clear;  // drop accumulator and count to zero
        logic take;   // accept the raw byte on this edge
        logic last;   // accepted byte closes the group
    } wh_step_t;

endpackage

// File: rtl/mix_whitener_cnt.sv
// Module: group counter. It counts accepted raw bytes modulo NUM_RAW and
// decides what happens on each edge: clear, take, or take and close.
// Assumes NUM_RAW >= 2 and a synchronous active-low reset.
module mix_whitener_cnt
    import mix_whitener_pkg::*;
#(
    parameter int NUM_RAW = 8
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     en_i,
    input  logic     raw_vld_i,
    output wh_step_t step_o
);
    localparam int CNT_W = (NUM_RAW > 2) ? $clog2(NUM_RAW) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_RAW - 1);

    logic [CNT_W-1:0] cnt_q;

    // Decode the step for this cycle from the enable, the strobe and the count.
    always_comb begin
        step_o.clear = ~rst_ni | ~en_i;
        step_o.take  = rst_ni & en_i & raw_vld_i;
        step_o.last  = step_o.take & (cnt_q == LAST_IDX);
    end

    // Count accepted bytes and wrap after the last byte of the group.
    always_ff @(posedge clk_i) begin
        if (step_o.clear) begin
            cnt_q <= '0;
        end else if (step_o.last) begin
            cnt_q <= '0;
        end else if (step_o.take) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mix_whitener_acc.sv
// Module: rotate-and-add accumulator. On each accepted byte it rotates the
// running value right by one bit and adds the byte modulo 2^W. It offers the
// updated value on next_o and clears itself when a group closes.
// Assumes the step decision comes from mix_whitener_cnt.
module mix_whitener_acc
    import mix_whitener_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  wh_step_t     step_i,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] next_o
);
    logic [W-1:0] acc_q;
    logic [W-1:0] rot;

    // Right rotation by one: lane i takes lane i+1, and the top lane takes lane 0.
    for (genvar i = 0; i < W; i++) begin : g_rot
        assign rot[i] = acc_q[(i + 1) % W];
    end

    // Form the updated value: modulo-2^W sum of the rotated accumulator and the byte.
    always_comb begin
        next_o = rot + raw_i;
    end

    // Keep the running value; restart from zero on clear or at the end of a group.
    always_ff @(posedge clk_i) begin
        if (step_i.clear || step_i.last) begin
            acc_q <= '0;
        end else if (step_i.take) begin
            acc_q <= next_o;
        end
    end
endmodule

// File: rtl/mix_whitener_out.sv
// Module: output register. It captures the closing sum and raises a
// one-cycle valid pulse. The data is held until the next capture and is
// cleared only by reset. Assumes a synchronous active-low reset.
module mix_whitener_out
    import mix_whitener_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  wh_step_t     step_i,
    input  logic [W-1:0] next_i,
    output logic [W-1:0] out_o,
    output logic         out_vld_o
);
    // Capture the final sum and pulse valid when a group closes.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            out_o     <= '0;
            out_vld_o <= 1'b0;
        end else begin
            out_vld_o <= step_i.last;
            if (step_i.last) begin
                out_o <= next_i;
            end
        end
    end
endmodule

// File: rtl/mix_whitener.sv
// Module: top of the rotate-and-add byte whitener. It folds NUM_RAW raw
// bytes into one byte and signals it with a one-cycle pulse. Assumes raw
// bytes arrive with a one-cycle strobe at any rate, including every cycle.
module mix_whitener
    import mix_whitener_pkg::*;
#(
    parameter int W       = 8,
    parameter int NUM_RAW = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         en_i,
    input  logic [W-1:0] raw_i,
    input  logic         raw_vld_i,
    output logic [W-1:0] out_o,
    output logic         out_vld_o
);
    wh_step_t     step;
    logic [W-1:0] next_sum;

    mix_whitener_cnt #(.NUM_RAW(NUM_RAW)) u_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (en_i),
        .raw_vld_i (raw_vld_i),
        .step_o    (step)
    );

    mix_whitener_acc #(.W(W)) u_acc (
        .clk_i  (clk_i),
        .step_i (step),
        .raw_i  (raw_i),
        .next_o (next_sum)
    );

    mix_whitener_out #(.W(W)) u_out (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .step_i    (step),
        .next_i    (next_sum),
        .out_o     (out_o),
        .out_vld_o (out_vld_o)
    );
endmodule

// File: rtl/mix_whitener_chk.sv
// Module: port-level checker for mix_whitener. It keeps its own count of
// accepted bytes and checks pulse timing, pulse width, the effect of reset
// and enable, and that the output is held between pulses.
module mix_whitener_chk #(
    parameter int W       = 8,
    parameter int NUM_RAW = 8
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         en_i,
    input logic [W-1:0] raw_i,
    input logic         raw_vld_i,
    input logic [W-1:0] out_o,
    input logic         out_vld_o
);
    localparam int CW = $clog2(NUM_RAW + 1);

    logic [1:0]    arm_q;
    logic [CW-1:0] seen_q;
    logic          ok;
    logic          closing;

    // Arm the history-based properties two edges after reset is released.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) arm_q <= 2'b00;
        else         arm_q <= {arm_q[0], 1'b1};
    end
    assign ok = arm_q[1];

    // Independent tally of the bytes accepted in the current group.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !en_i)                     seen_q <= '0;
        else if (raw_vld_i && closing)            seen_q <= '0;
        else if (raw_vld_i)                       seen_q <= seen_q + 1'b1;
    end
    assign closing = (seen_q == CW'(NUM_RAW - 1));

    // R1: a reset edge leaves valid low and data zero.
    p_reset_clear_r1: assert property (@(posedge clk_i)
        !rst_ni |=> (!out_vld_o && out_o == '0));

    // R3: accepting the last byte of a group raises valid on the next cycle.
    p_group_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && raw_vld_i && closing) |=> out_vld_o);

    // R7: a pulse only follows an edge that accepted a closing byte.
    p_pulse_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ok && out_vld_o) |-> $past(en_i && raw_vld_i && closing));

    // R4: valid never stays high for two cycles.
    p_single_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_vld_o |=> !out_vld_o);

    // R6: an edge sampled with the enable low gives no pulse.
    p_disabled_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !out_vld_o);

    // R9: without a pulse the data output holds.
    p_hold_data_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ok && !out_vld_o) |-> $stable(out_o));
endmodule

bind mix_whitener mix_whitener_chk #(.W(W), .NUM_RAW(NUM_RAW)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .raw_i     (raw_i),
    .raw_vld_i (raw_vld_i),
    .out_o     (out_o),
    .out_vld_o (out_vld_o)
);

// File: tb/mix_whitener_test.sv
// Bench for mix_whitener: single-bit sweep over all 64 raw bit positions,
// carry-heavy groups, back-to-back and gapped strobes, enable drop mid-group.
module mix_whitener_test;
    localparam int  W        = 8;
    localparam int  N        = 8;
    localparam time CLK_PER  = 10ns;
    localparam int  WATCHDOG = 100000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic [W-1:0] raw = '0;
    logic         raw_vld = 1'b0;
    logic [W-1:0] out;
    logic         out_vld;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    logic [W-1:0] m_acc = '0;
    int           m_cnt = 0;
    logic [W-1:0] last_out = '0;

    mix_whitener #(.W(W), .NUM_RAW(N)) uut (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .raw_i(raw),
        .raw_vld_i(raw_vld), .out_o(out), .out_vld_o(out_vld)
    );

    always #(CLK_PER / 2) clk = ~clk;

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] rotr1(input logic [W-1:0] a);
        return {a[0], a[W-1:1]};
    endfunction

    // Offer one byte at a negedge and check the outputs one edge later.
    task automatic send(input logic [W-1:0] b, input string req);
        raw = b;
        raw_vld = 1'b1;
        @(negedge clk);
        raw_vld = 1'b0;
        m_acc = rotr1(m_acc) + b;
        m_cnt++;
        if (m_cnt == N) begin
            check({req, "/R3 pulse"}, {7'd0, out_vld}, 8'd1);
            check({req, "/R2 value"}, out, m_acc);
            last_out = m_acc;
            m_acc = '0;
            m_cnt = 0;
        end else begin
            check({req, "/R4 no pulse"}, {7'd0, out_vld}, 8'd0);
        end
    endtask

    // Idle cycles with junk on the data lines: no pulse, output held.
    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            raw = W'(8'hA5 ^ i * 37);
            @(negedge clk);
            check({req, "/R4 idle"}, {7'd0, out_vld}, 8'd0);
            check({req, "/R9 hold"}, out, last_out);
        end
    endtask

    // Watchdog: counts as a failure and still reaches the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 vld", {7'd0, out_vld}, 8'd0);
        check("R1 data", out, 8'd0);
        rst_n = 1'b1;
        en = 1'b1;
        @(negedge clk);

        // R2/R3 sweep: one set bit per group at each of the 64 positions, back-to-back (R7).
        for (int k = 0; k < N; k++) begin
            for (int b = 0; b < W; b++) begin
                for (int j = 0; j < N; j++) begin
                    raw = (j == k) ? W'(1 << b) : '0;
                    raw_vld = 1'b1;
                    @(negedge clk);
                end
                raw_vld = 1'b0;
                // Byte k is rotated N-1-k more times after its addition.
                check("R2 sweep pulse", {7'd0, out_vld}, 8'd1);
                check("R2 sweep value", out, W'(1 << ((b - (N - 1 - k) + 8 * W) % W)));
                last_out = W'(1 << ((b - (N - 1 - k) + 8 * W) % W));
                @(negedge clk);
                check("R4 sweep drop", {7'd0, out_vld}, 8'd0);
            end
        end

        // Carry-heavy group, back-to-back: R7 with R2.
        for (int j = 0; j < N; j++) send(8'hFF, "R7 ones");
        // Counting group with gaps of junk between bytes: R8.
        for (int j = 0; j < N; j++) begin
            send(W'(j * 29 + 3), "R8 gapped");
            idle(j % 3 + 1, "R8");
        end
        // Second group straight after: R5 fresh start.
        for (int j = 0; j < N; j++) send(W'(8'h80 >> j), "R5 fresh");

        // Enable drop mid-group with strobes high: R6.
        for (int j = 0; j < 3; j++) send(W'(8'h3C + j), "R6 partial");
        en = 1'b0;
        raw = 8'h77;
        raw_vld = 1'b1;
        repeat (N + 2) begin
            @(negedge clk);
            check("R6 disabled pulse", {7'd0, out_vld}, 8'd0);
            check("R9 hold on disable", out, last_out);
        end
        raw_vld = 1'b0;
        en = 1'b1;
        m_acc = '0;
        m_cnt = 0;
        for (int j = 0; j < N; j++) send(W'(j * 71 + 5), "R6 after");
        idle(4, "R6 tail");

        // Reset mid-group: R1.
        for (int j = 0; j < 2; j++) send(8'h11, "R1 pre");
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset vld", {7'd0, out_vld}, 8'd0);
        check("R1 reset data", out, 8'd0);
        rst_n = 1'b1;
        m_acc = '0;
        m_cnt = 0;
        last_out = '0;
        for (int j = 0; j < N; j++) send(W'(255 - j * 13), "R1 post");

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule